// File: doc/BRIEF.md
# Shared Timer Dual Capture Unit

This block holds one 16-bit core timer that counts up or down by one step on each cycle of a count strobe. Two capture channels watch their own input pins. When a channel's selected edge appears on its pin, the channel copies the core timer's current value into its capture register. It also raises that channel's request flag.

Each pin is synchronised and then filtered. A new level is accepted only after it has been seen unchanged for a set number of consecutive clocks, so short glitches never cause a capture. The core timer raises its own request flag when it wraps: from all-ones to zero when counting up, and from zero to all-ones when counting down.

There are three interrupt sources: the core timer and the two channels. Each source has an 8-bit control word holding a request flag, an enable bit and two priority fields. Its interrupt line is high while both the flag and the enable are set. A single-port register interface writes the timer, the capture registers, a control register and the three control words. A separate combinational read port returns any register.

Top module: `shared_timer_capture`

## Requirements
- R1: After reset every register reads 0000h and all three interrupt lines are low.
- R2: With the run bit set and the direction bit clear, the core timer increases by one on each clock in which `cnt_tick` is high. It holds its value when `cnt_tick` is low or the run bit is clear.
- R3: With the run bit and the direction bit both set, the core timer decreases by one on each clock in which `cnt_tick` is high.
- R4: A step from FFFFh to 0000h while counting up sets the core timer's request flag. A step from 0000h to FFFFh while counting down sets it as well.
- R5: When a channel accepts a selected edge, its capture register loads the core timer value held in the clock before the load, and that channel's request flag is set.
- R6: Each channel's 2-bit edge select uses these codes: 00 disables capture, 01 captures on rising edges, 10 on falling edges, 11 on both. An edge that is not selected changes nothing.
- R7: A pin level is accepted only after 8 consecutive synchronised samples agree on it. The pin passes through a two-stage synchroniser first. A pin held at a new level for exactly 8 clock samples is captured. A pulse of 7 samples is ignored.
- R8: A control word reads back in bits 7:0 as request flag (bit 7), enable (bit 6), interrupt level (bits 5:2) and group level (bits 1:0). Bits 15:8 read as zero whatever is written to them.
- R9: `irq[i]` is high exactly when source i has both its request flag and its enable bit set. Index 0 is the core timer, index 1 is channel 0, and index 2 is channel 1.
- R10: A request flag stays set until software writes 0 to bit 7 of its control word. If a hardware set and a software clear of the same flag fall in the same clock, the flag ends up set.
- R11: A capture register takes bus writes only while its channel's edge select is 00. While the select is non-zero, writes to it are ignored.
- R12: A bus write to the core timer loads the written value. It takes priority over counting in the same clock, and that clock raises no wrap flag.
- R13: Register addresses:
  - 0: core timer
  - 1: capture register of channel 0
  - 2: capture register of channel 1
  - 3: control register, with run at bit 0, direction at bit 1, channel 0 edge select at bits 3:2, channel 1 edge select at bits 5:4, and all other bits reading 0
  - 4, 5, 6: control words for the core timer, channel 0 and channel 1
  - 7: reads 0 and ignores writes

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count strobe; the timer steps once per clock in which it is high |
| cap_pin | input | 2 | Capture input pins, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Combinational read data |
| irq | output | 3 | Interrupt lines: core timer, channel 0, channel 1 |

## Verification
The following rules are checked on every clock: single steps of the counter in each direction, a bus load winning over counting, a wrap or capture event leaving its flag set, and a capture copying the previous timer value. Also checked on every clock: frozen capture registers while a select is active, no capture event with a disabled select, flags that only software can clear, and no interrupt without a flag. The length of the filter window can only be shown by the bench's scenarios, with pulses one sample short of the window and pulses exactly at it. The same applies to the simultaneous clear-and-set race, the read-back layout of the control words, and whole sequences driven against a behavioural model of the filter and timer.

// File: rtl/stc_pkg.sv
`timescale 1ns/1ps
package stc_pkg;

  localparam int NUM_CAP = 2;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_TMR  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CAP0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_ICW0 = 3'd4;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic       req;
    logic       ena;
    logic [3:0] ilvl;
    logic [1:0] glvl;
  } icw_t;

  // Decide whether an accepted pin transition counts for a channel.
  function automatic logic edge_hit(input edge_sel_e s, input logic r, input logic f);
    case (s)
      EDGE_RISE: return r;
      EDGE_FALL: return f;
      EDGE_ANY:  return r | f;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/stc_pin_filter.sv
`timescale 1ns/1ps
module stc_pin_filter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic          lvl_q;
  logic [CW-1:0] run_len_q;
  logic          differ;
  logic          accept;

  assign differ = sync_q[1] ^ lvl_q;
  assign accept = differ && (run_len_q == CW'(FILT_LEN - 1));
  assign rise   = accept &  sync_q[1];
  assign fall   = accept & ~sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      lvl_q     <= 1'b0;
      run_len_q <= '0;
    end else begin
      sync_q <= {sync_q[0], pin};
      if (!differ) begin
        run_len_q <= '0;
      end else if (accept) begin
        run_len_q <= '0;
        lvl_q     <= sync_q[1];
      end else begin
        run_len_q <= run_len_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/stc_core_timer.sv
`timescale 1ns/1ps
module stc_core_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          down,
  input  logic          tick,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] count,
  output logic          wrap
);
  localparam logic [TW-1:0] ALL_ONES = '1;

  function automatic logic [TW-1:0] step(input logic [TW-1:0] v, input logic dn);
    return dn ? v - TW'(1) : v + TW'(1);
  endfunction

  function automatic logic at_edge(input logic [TW-1:0] v, input logic dn);
    return dn ? (v == '0) : (v == ALL_ONES);
  endfunction

  logic advance;
  assign advance = run && tick && !load;
  assign wrap    = advance && at_edge(count, down);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= load_val;
    else if (advance) count <= step(count, down);
  end
endmodule

// File: rtl/stc_irq_ctrl.sv
`timescale 1ns/1ps
module stc_irq_ctrl
  import stc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [$bits(icw_t)-1:0] wdata,
  input  logic                 hw_set,
  output icw_t                 icw,
  output logic                 irq
);
  icw_t icw_d;

  always_comb begin
    icw_d     = wr ? icw_t'(wdata) : icw;
    icw_d.req = icw_d.req | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) icw <= '0;
    else        icw <= icw_d;
  end

  assign irq = icw.req & icw.ena;
endmodule

// File: rtl/shared_timer_capture.sv
`timescale 1ns/1ps
module shared_timer_capture
  import stc_pkg::*;
#(
  parameter int TW       = 16,
  parameter int FILT_LEN = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_tick,
  input  logic [NUM_CAP-1:0]  cap_pin,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [TW-1:0]       wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [TW-1:0]       rd_data,
  output logic [NUM_CAP:0]    irq
);
  localparam int NSRC  = NUM_CAP + 1;
  localparam int ICW_W = $bits(icw_t);

  // control register
  logic            run_q;
  logic            dir_q;
  edge_sel_e       esel_q [NUM_CAP];
  logic            ctrl_wr;
  logic [TW-1:0]   ctrl_rd;

  // timer and capture
  logic [TW-1:0]      tmr_q;
  logic               tmr_wr;
  logic               tmr_wrap;
  logic [TW-1:0]      cap_q [NUM_CAP];
  logic [NUM_CAP-1:0] cap_evt;
  logic [NUM_CAP-1:0] cap_wr;
  logic [NUM_CAP-1:0] esel_on;
  logic [NUM_CAP-1:0] pin_rise;
  logic [NUM_CAP-1:0] pin_fall;

  // interrupt sources
  icw_t            icw [NSRC];
  logic [NSRC-1:0] icr_wr;
  logic [NSRC-1:0] hw_set;
  logic [NSRC-1:0] flag_q;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign tmr_wr  = wr_en && (wr_addr == A_TMR);
  assign hw_set  = {cap_evt, tmr_wrap};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
      for (int c = 0; c < NUM_CAP; c++) esel_q[c] <= EDGE_OFF;
    end else if (ctrl_wr) begin
      run_q <= wr_data[0];
      dir_q <= wr_data[1];
      for (int c = 0; c < NUM_CAP; c++) esel_q[c] <= edge_sel_e'(wr_data[2+2*c +: 2]);
    end
  end

  always_comb begin
    ctrl_rd    = '0;
    ctrl_rd[0] = run_q;
    ctrl_rd[1] = dir_q;
    for (int c = 0; c < NUM_CAP; c++) ctrl_rd[2+2*c +: 2] = esel_q[c];
  end

  stc_core_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .down     (dir_q),
    .tick     (cnt_tick),
    .load     (tmr_wr),
    .load_val (wr_data),
    .count    (tmr_q),
    .wrap     (tmr_wrap)
  );

  for (genvar c = 0; c < NUM_CAP; c++) begin : g_ch
    stc_pin_filter #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (cap_pin[c]),
      .rise  (pin_rise[c]),
      .fall  (pin_fall[c])
    );
    assign esel_on[c] = (esel_q[c] != EDGE_OFF);
    assign cap_evt[c] = edge_hit(esel_q[c], pin_rise[c], pin_fall[c]);
    assign cap_wr[c]  = wr_en && (wr_addr == A_CAP0 + ADDR_W'(c)) && !esel_on[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CAP; c++) cap_q[c] <= '0;
    end else begin
      for (int c = 0; c < NUM_CAP; c++) begin
        if (cap_evt[c])     cap_q[c] <= tmr_q;
        else if (cap_wr[c]) cap_q[c] <= wr_data;
      end
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign icr_wr[i] = wr_en && (wr_addr == A_ICW0 + ADDR_W'(i));
    stc_irq_ctrl u_icr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (icr_wr[i]),
      .wdata  (wr_data[ICW_W-1:0]),
      .hw_set (hw_set[i]),
      .icw    (icw[i]),
      .irq    (irq[i])
    );
    assign flag_q[i] = icw[i].req;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_TMR)  rd_data = tmr_q;
    if (rd_addr == A_CTRL) rd_data = ctrl_rd;
    for (int c = 0; c < NUM_CAP; c++)
      if (rd_addr == A_CAP0 + ADDR_W'(c)) rd_data = cap_q[c];
    for (int i = 0; i < NSRC; i++)
      if (rd_addr == A_ICW0 + ADDR_W'(i)) rd_data = TW'(icw[i]);
  end
endmodule

// File: rtl/stc_checker.sv
`timescale 1ns/1ps
module stc_checker
  import stc_pkg::*;
#(
  parameter int TW = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                run,
  input logic                dir,
  input logic                tick,
  input logic                tmr_wr,
  input logic [TW-1:0]       wdata,
  input logic [TW-1:0]       tmr_q,
  input logic                wrap,
  input logic [NUM_CAP-1:0]  cap_evt,
  input logic [NUM_CAP-1:0]  esel_on,
  input logic [TW-1:0]       cap_q [NUM_CAP],
  input logic [NUM_CAP:0]    flag,
  input logic [NUM_CAP:0]    icr_wr,
  input logic [NUM_CAP:0]    irq
);
  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !dir && !tmr_wr) |=> tmr_q == $past(tmr_q) + TW'(1));

  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && dir && !tmr_wr) |=> tmr_q == $past(tmr_q) - TW'(1));

  a_r12_bus_load: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |=> tmr_q == $past(wdata));

  a_r4_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag[0]);

  for (genvar c = 0; c < NUM_CAP; c++) begin : g_c
    a_r5_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[c] |=> cap_q[c] == $past(tmr_q));
    a_r5_cap_flag: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[c] |=> flag[c+1]);
    a_r11_cap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (esel_on[c] && !cap_evt[c]) |=> $stable(cap_q[c]));
    a_r6_off_no_event: assert property (@(posedge clk) disable iff (!rst_n)
      !esel_on[c] |-> !cap_evt[c]);
  end

  for (genvar i = 0; i <= NUM_CAP; i++) begin : g_s
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !icr_wr[i]) |=> flag[i]);
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> flag[i]);
  end
endmodule

bind shared_timer_capture stc_checker #(.TW(TW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run_q),
  .dir     (dir_q),
  .tick    (cnt_tick),
  .tmr_wr  (tmr_wr),
  .wdata   (wr_data),
  .tmr_q   (tmr_q),
  .wrap    (tmr_wrap),
  .cap_evt (cap_evt),
  .esel_on (esel_on),
  .cap_q   (cap_q),
  .flag    (flag_q),
  .icr_wr  (icr_wr),
  .irq     (irq)
);

// File: tb/shared_timer_capture_bench.sv
`timescale 1ns/1ps
module shared_timer_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_tick = 1'b0;
  logic [1:0]  cap_pin = 2'b00;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [15:0] wr_data = 16'h0;
  logic [2:0]  rd_addr = 3'd0;
  logic [15:0] rd_data;
  logic [2:0]  irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [15:0] obs [8];

  shared_timer_capture u_shared_timer_capture (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cap_pin(cap_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #4 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_tmr = 0;
  logic [15:0] m_cap [2] = '{16'h0, 16'h0};
  logic        m_run = 0, m_dir = 0;
  logic [1:0]  m_sel [2] = '{2'b0, 2'b0};
  logic [7:0]  m_icw [3] = '{8'h0, 8'h0, 8'h0};
  bit          m_lvl [2] = '{0, 0};
  bit          hist [2][16];   // hist[c][j] = pin sampled j clocks ago

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_tmr = 0; m_run = 0; m_dir = 0;
      for (int c = 0; c < 2; c++) begin
        m_cap[c] = 0; m_sel[c] = 0; m_lvl[c] = 0;
        for (int j = 0; j < 16; j++) hist[c][j] = 0;
      end
      for (int i = 0; i < 3; i++) m_icw[i] = 0;
    end else begin
      logic [15:0] t_old;
      bit hit [2];
      bit wrapped;
      t_old = m_tmr;
      wrapped = 0;
      for (int c = 0; c < 2; c++) begin
        bit agree;
        bit nv;
        nv = !m_lvl[c];
        agree = 1;
        for (int k = 2; k <= 9; k++) if (hist[c][k] != nv) agree = 0;
        hit[c] = agree && ((m_sel[c] == 2'b01 && nv) || (m_sel[c] == 2'b10 && !nv) || m_sel[c] == 2'b11);
        if (agree) m_lvl[c] = nv;
        for (int j = 15; j >= 2; j--) hist[c][j] = hist[c][j-1];
        hist[c][1] = cap_pin[c];
      end
      if (wr_en && wr_addr == 3'd0) m_tmr = wr_data;
      else if (m_run && cnt_tick) begin
        if (m_dir) begin wrapped = (m_tmr == 16'h0000); m_tmr = m_tmr - 1; end
        else begin wrapped = (m_tmr == 16'hFFFF); m_tmr = m_tmr + 1; end
      end
      for (int c = 0; c < 2; c++) begin
        if (hit[c]) m_cap[c] = t_old;
        else if (wr_en && wr_addr == 3'(1 + c) && m_sel[c] == 2'b00) m_cap[c] = wr_data;
      end
      for (int i = 0; i < 3; i++) begin
        bit hw;
        hw = (i == 0) ? wrapped : hit[i-1];
        if (wr_en && wr_addr == 3'(4 + i)) m_icw[i] = wr_data[7:0];
        if (hw) m_icw[i][7] = 1'b1;
      end
      if (wr_en && wr_addr == 3'd3) begin
        m_run = wr_data[0]; m_dir = wr_data[1];
        m_sel[0] = wr_data[3:2]; m_sel[1] = wr_data[5:4];
      end
    end
  end

  function automatic logic [15:0] model_read(input int a);
    case (a)
      0: return m_tmr;
      1: return m_cap[0];
      2: return m_cap[1];
      3: return {10'b0, m_sel[1], m_sel[0], m_dir, m_run};
      4, 5, 6: return {8'h00, m_icw[a-4]};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // every-cycle sweep of the read port against the model
  always @(negedge clk) begin
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #0.4;
      obs[a] = rd_data;
      if (cyc > 0) begin
        if (a == 0)                check("R2 timer vs model", rd_data, model_read(a));
        else if (a == 1 || a == 2) check("R5 capture vs model", rd_data, model_read(a));
        else if (a >= 4 && a <= 6) check("R8 control word vs model", rd_data, model_read(a));
        else                       check("R13 map vs model", rd_data, model_read(a));
      end
    end
    if (cyc > 0)
      check("R9 irq vs model", {13'b0, irq},
            {13'b0, m_icw[2][7] & m_icw[2][6], m_icw[1][7] & m_icw[1][6], m_icw[0][7] & m_icw[0][6]});
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look();
    #3.5;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    failures++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    look();
    for (int a = 0; a < 8; a++) check("R1 reset register", obs[a], 16'h0000);
    check("R1 reset irq", {13'b0, irq}, 16'h0000);

    // R12 load wins over counting, then R2 counting and holding
    bus_wr(3'd3, 16'h0001);
    @(negedge clk);
    cnt_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0010;
    @(negedge clk);
    wr_en = 1'b0;
    look();
    check("R12 bus load over tick", obs[0], 16'h0010);
    @(negedge clk); look();
    check("R2 count up", obs[0], 16'h0011);
    @(negedge clk); cnt_tick = 1'b0;
    wait_n(2); look();
    check("R2 hold without tick", obs[0], 16'h0012);

    // R4 overflow
    bus_wr(3'd0, 16'hFFFE);
    cnt_tick = 1'b1; wait_n(2); cnt_tick = 1'b0; look();
    check("R4 overflow value", obs[0], 16'h0000);
    check("R4 overflow flag", obs[4], 16'h0080);
    bus_wr(3'd4, 16'h0000); look();
    check("R10 clear by write 0", obs[4], 16'h0000);

    // R3 down count and underflow
    bus_wr(3'd3, 16'h0003);
    bus_wr(3'd0, 16'h0002);
    cnt_tick = 1'b1; @(negedge clk); look();
    check("R3 count down", obs[0], 16'h0001);
    wait_n(2); cnt_tick = 1'b0; look();
    check("R4 underflow value", obs[0], 16'hFFFF);
    check("R4 underflow flag", obs[4], 16'h0080);

    // R8 layout, upper byte ignored; R9 enable without flag
    bus_wr(3'd4, 16'hFF7F); look();
    check("R8 upper byte zero", obs[4], 16'h007F);
    check("R9 no irq without flag", {13'b0, irq}, 16'h0000);

    // R10 hardware set wins over simultaneous clear
    bus_wr(3'd0, 16'h0000);
    @(negedge clk);
    cnt_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h007F;
    @(negedge clk);
    wr_en = 1'b0; cnt_tick = 1'b0; look();
    check("R10 set beats clear", obs[4], 16'h00FF);
    check("R9 irq with flag and enable", {13'b0, irq}, 16'h0001);
    bus_wr(3'd4, 16'h0040); look();
    check("R9 irq drops on clear", {13'b0, irq}, 16'h0000);

    // R5/R6 capture: ch0 rising, ch1 falling, timer frozen
    bus_wr(3'd3, 16'h0024);
    bus_wr(3'd0, 16'h1234);
    cap_pin = 2'b11;
    wait_n(12); look();
    check("R5 ch0 capture value", obs[1], 16'h1234);
    check("R5 ch0 flag", obs[5], 16'h0080);
    check("R6 ch1 rising not selected", obs[2], 16'h0000);
    check("R6 ch1 flag untouched", obs[6], 16'h0000);
    bus_wr(3'd0, 16'h5678);
    cap_pin[1] = 1'b0;
    wait_n(12); look();
    check("R6 ch1 falling capture", obs[2], 16'h5678);
    check("R5 ch1 flag", obs[6], 16'h0080);
    check("R6 ch0 no edge", obs[1], 16'h1234);

    // R7 filter window, ch0 both edges
    bus_wr(3'd5, 16'h0000);
    bus_wr(3'd3, 16'h002C);
    bus_wr(3'd0, 16'h9ABC);
    cap_pin[0] = 1'b0; wait_n(7); cap_pin[0] = 1'b1;
    wait_n(14); look();
    check("R7 seven-sample pulse ignored", obs[1], 16'h1234);
    check("R7 no flag from short pulse", obs[5], 16'h0000);
    cap_pin[0] = 1'b0; wait_n(8); cap_pin[0] = 1'b1;
    wait_n(14); look();
    check("R7 eight-sample pulse captured", obs[1], 16'h9ABC);
    check("R7 flag from full pulse", obs[5], 16'h0080);

    // R11 write protection
    bus_wr(3'd1, 16'h1111); look();
    check("R11 write ignored while selected", obs[1], 16'h9ABC);
    bus_wr(3'd3, 16'h0020);
    bus_wr(3'd1, 16'h1111); look();
    check("R11 write taken when off", obs[1], 16'h1111);
    check("R13 control readback", obs[3], 16'h0020);
    cap_pin[0] = 1'b0; wait_n(12); look();
    check("R6 disabled channel ignores edge", obs[1], 16'h1111);
    bus_wr(3'd7, 16'hFFFF); look();
    check("R13 address 7 reads zero", obs[7], 16'h0000);

    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      cnt_tick = 1'($urandom % 2);
      wr_en    = ($urandom % 6) == 0;
      wr_addr  = 3'($urandom % 8);
      wr_data  = 16'($urandom);
      for (int c = 0; c < 2; c++) if (($urandom % 7) == 0) cap_pin[c] = ~cap_pin[c];
    end
    @(negedge clk); wr_en = 1'b0;
    wait_n(2); look();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule